// File: doc/BRIEF.md
# Big-Endian Load/Store Byte Aligner

This block sits between the load/store stage of a processor core and a data memory that is one word wide and byte addressed. For a store it turns the register operand into the word that goes to memory and a per-byte write-enable mask. For a load it takes the word read from memory, picks out the addressed byte or halfword, and widens it to a full word. The widening uses either the sign bit or zeros, depending on the request. Byte order is big-endian, so the byte at offset 0 within a word is the most significant byte, in bits 31:24.

The caller computes the effective address and passes in only its low offset bits. Accesses that break the natural alignment of their size are flagged. A flagged access writes nothing and returns zero. All outputs are registered and appear on the clock edge after the request is taken.

Top module: `bsa_aligner`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `wr_en` is 0, `wr_data` is 0, `ld_data` is 0 and `misalign` is 0.
- R2: Byte store (size code 00) at offset k: `wr_data` holds the low 8 bits of `st_data` copied into all four byte lanes, and only `wr_en[3-k]` is set, where `wr_en[3]` guards bits 31:24.
- R3: Halfword store (size code 01) at offset 0 sets `wr_en` to 4'b1100 and at offset 2 sets it to 4'b0011; `wr_data` holds the low 16 bits of `st_data` in both halves.
- R4: Word store (size code 10) at offset 0 sets `wr_en` to 4'b1111 and passes `st_data` through to `wr_data` unchanged.
- R5: Unsigned narrow load (`req_unsigned`=1) returns the byte in `mem_rdata` bits [31-8k:24-8k] for offset k, or for a halfword the upper half at offset 0 and the lower half at offset 2, with zero fill above it.
- R6: Signed narrow load (`req_unsigned`=0) returns the same byte or halfword with its top bit copied into every higher bit.
- R7: Word load at offset 0 returns `mem_rdata` unchanged, whatever the value of `req_unsigned`.
- R8: A halfword at an odd offset, a word at a nonzero offset, or size code 11 raises `misalign`. The same access drives `wr_en` to 0 and `ld_data` to 0.
- R9: A load never sets any bit of `wr_en`. A cycle without `req_valid` gives `wr_en`=0 and `misalign`=0 on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | An access is presented this cycle |
| req_store | input | 1 | 1 = store, 0 = load |
| req_unsigned | input | 1 | Loads: 1 = zero fill, 0 = sign fill |
| req_size | input | 2 | 00 byte, 01 halfword, 10 word, 11 reserved |
| req_ofs | input | 2 | Low bits of the effective address (byte offset within the word) |
| st_data | input | 32 | Register operand of a store |
| mem_rdata | input | 32 | Word read from memory for a load |
| wr_en | output | 4 | Per-byte write enables; bit 3 guards bits 31:24 |
| wr_data | output | 32 | Word driven toward memory |
| ld_data | output | 32 | Widened load result |
| misalign | output | 1 | The access broke its alignment rule |

## Verification
Every result is due exactly one rising edge after the cycle in which the request is presented. Nothing takes more than one cycle, and a request does not affect any later cycle. The bench changes inputs on the falling edge and samples the outputs on the next falling edge, which is half a period after the capturing edge. Each request is then dropped for at least one cycle, so a stale output would be noticed by the idle check.

// File: rtl/bsa_pkg.sv
package bsa_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_RSVD = 2'b11
  } acc_size_e;
endpackage

// File: rtl/bsa_align_check.sv
module bsa_align_check
  import bsa_pkg::*;
#(
  parameter int LANES = 4,
  parameter int OFS_W = $clog2(LANES)
) (
  input  acc_size_e        size_i,
  input  logic [OFS_W-1:0] ofs_i,
  output logic             misalign_o,
  output logic [LANES-1:0] lane_en_o
);
  function automatic logic breaks_rule(acc_size_e sz, logic [OFS_W-1:0] ofs);
    case (sz)
      SZ_BYTE: return 1'b0;
      SZ_HALF: return ofs[0];
      SZ_WORD: return (ofs != '0);
      default: return 1'b1;
    endcase
  endfunction

  assign misalign_o = breaks_rule(size_i, ofs_i);

  // Lane g carries the byte at offset LANES-1-g (big-endian numbering).
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    localparam int BYTE_OFS = LANES - 1 - g;
    logic hit;
    always_comb begin
      case (size_i)
        SZ_BYTE: hit = (int'(ofs_i) == BYTE_OFS);
        SZ_HALF: hit = ((int'(ofs_i) >> 1) == (BYTE_OFS >> 1));
        SZ_WORD: hit = 1'b1;
        default: hit = 1'b0;
      endcase
    end
    assign lane_en_o[g] = hit & ~misalign_o;
  end
endmodule

// File: rtl/bsa_store_pack.sv
module bsa_store_pack
  import bsa_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LANES  = DATA_W / 8
) (
  input  acc_size_e         size_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] wdata_o
);
  localparam int HALVES = LANES / 2;

  function automatic logic [DATA_W-1:0] spread(acc_size_e sz, logic [DATA_W-1:0] d);
    case (sz)
      SZ_BYTE: return {LANES{d[7:0]}};
      SZ_HALF: return {HALVES{d[15:0]}};
      default: return d;
    endcase
  endfunction

  assign wdata_o = spread(size_i, data_i);
endmodule

// File: rtl/bsa_load_extract.sv
module bsa_load_extract
  import bsa_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LANES  = DATA_W / 8,
  parameter int OFS_W  = $clog2(LANES)
) (
  input  acc_size_e         size_i,
  input  logic [OFS_W-1:0]  ofs_i,
  input  logic              unsigned_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic [DATA_W-1:0] result_o
);
  localparam int HALVES = LANES / 2;

  function automatic logic [7:0] pick_byte(logic [DATA_W-1:0] w, logic [OFS_W-1:0] ofs);
    return w[8*(LANES-1-int'(ofs)) +: 8];
  endfunction

  function automatic logic [15:0] pick_half(logic [DATA_W-1:0] w, logic [OFS_W-1:0] ofs);
    return w[16*(HALVES-1-(int'(ofs) >> 1)) +: 16];
  endfunction

  function automatic logic [DATA_W-1:0] widen8(logic [7:0] b, logic uns);
    return {{(DATA_W-8){b[7] & ~uns}}, b};
  endfunction

  function automatic logic [DATA_W-1:0] widen16(logic [15:0] h, logic uns);
    return {{(DATA_W-16){h[15] & ~uns}}, h};
  endfunction

  always_comb begin
    case (size_i)
      SZ_BYTE: result_o = widen8(pick_byte(rdata_i, ofs_i), unsigned_i);
      SZ_HALF: result_o = widen16(pick_half(rdata_i, ofs_i), unsigned_i);
      default: result_o = rdata_i;
    endcase
  end
endmodule

// File: rtl/bsa_aligner.sv
module bsa_aligner
  import bsa_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LANES  = DATA_W / 8,
  parameter int OFS_W  = $clog2(LANES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_store,
  input  logic              req_unsigned,
  input  logic [1:0]        req_size,
  input  logic [OFS_W-1:0]  req_ofs,
  input  logic [DATA_W-1:0] st_data,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [LANES-1:0]  wr_en,
  output logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] ld_data,
  output logic              misalign
);
  acc_size_e         size_c;
  logic              bad_c;
  logic [LANES-1:0]  lanes_c;
  logic [DATA_W-1:0] packed_c;
  logic [DATA_W-1:0] loaded_c;

  assign size_c = acc_size_e'(req_size);

  bsa_align_check #(.LANES(LANES), .OFS_W(OFS_W)) u_check (
    .size_i    (size_c),
    .ofs_i     (req_ofs),
    .misalign_o(bad_c),
    .lane_en_o (lanes_c)
  );

  bsa_store_pack #(.DATA_W(DATA_W), .LANES(LANES)) u_pack (
    .size_i (size_c),
    .data_i (st_data),
    .wdata_o(packed_c)
  );

  bsa_load_extract #(.DATA_W(DATA_W), .LANES(LANES), .OFS_W(OFS_W)) u_extract (
    .size_i    (size_c),
    .ofs_i     (req_ofs),
    .unsigned_i(req_unsigned),
    .rdata_i   (mem_rdata),
    .result_o  (loaded_c)
  );

  // Named events of the captured request, kept for the assertions.
  logic      q_valid;
  logic      q_store;
  logic      q_unsigned;
  acc_size_e q_size;

  wire take_store = req_valid & req_store & ~bad_c;
  wire take_load  = req_valid & ~req_store & ~bad_c;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_en      <= '0;
      wr_data    <= '0;
      ld_data    <= '0;
      misalign   <= 1'b0;
      q_valid    <= 1'b0;
      q_store    <= 1'b0;
      q_unsigned <= 1'b0;
      q_size     <= SZ_BYTE;
    end else begin
      wr_en      <= take_store ? lanes_c : '0;
      wr_data    <= (req_valid & req_store) ? packed_c : '0;
      ld_data    <= take_load ? loaded_c : '0;
      misalign   <= req_valid & bad_c;
      q_valid    <= req_valid;
      q_store    <= req_store;
      q_unsigned <= req_unsigned;
      q_size     <= size_c;
    end
  end

  AST_MISALIGN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    misalign |-> (wr_en == '0 && ld_data == '0)); // R8
  AST_BYTE_ONE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
    (q_valid && q_store && q_size == SZ_BYTE) |-> ($countones(wr_en) == 1)); // R2
  AST_HALF_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    (q_valid && q_store && q_size == SZ_HALF && !misalign) |->
      (wr_en == 4'b1100 || wr_en == 4'b0011)); // R3
  AST_WORD_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    (q_valid && q_store && q_size == SZ_WORD && !misalign) |-> (wr_en == 4'b1111)); // R4
  AST_UNSIGNED_BYTE_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    (q_valid && !q_store && q_unsigned && q_size == SZ_BYTE) |-> (ld_data[DATA_W-1:8] == '0)); // R5
  AST_SIGNED_BYTE_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    (q_valid && !q_store && !q_unsigned && q_size == SZ_BYTE) |->
      (ld_data[DATA_W-1:8] == '0 || ld_data[DATA_W-1:7] == '1)); // R6
  AST_LOAD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (!q_valid || !q_store) |-> (wr_en == '0)); // R9
  AST_IDLE_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    !q_valid |-> !misalign); // R9
endmodule

// File: tb/bsa_aligner_test.sv
module bsa_aligner_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_store = 1'b0, req_unsigned = 1'b0;
  logic [1:0]  req_size = 2'b00, req_ofs = 2'b00;
  logic [31:0] st_data = '0, mem_rdata = '0;
  logic [3:0]  wr_en;
  logic [31:0] wr_data, ld_data;
  logic        misalign;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  bsa_aligner uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_store(req_store),
    .req_unsigned(req_unsigned), .req_size(req_size), .req_ofs(req_ofs),
    .st_data(st_data), .mem_rdata(mem_rdata), .wr_en(wr_en),
    .wr_data(wr_data), .ld_data(ld_data), .misalign(misalign)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Drive one request on a falling edge, results are checked one edge later.
  task automatic issue(logic st, logic uns, logic [1:0] sz, logic [1:0] ofs,
                       logic [31:0] sd, logic [31:0] rd);
    @(negedge clk);
    req_valid = 1'b1; req_store = st; req_unsigned = uns;
    req_size = sz; req_ofs = ofs; st_data = sd; mem_rdata = rd;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 wr_en", {28'd0, wr_en}, 32'd0);
    chk("R1 wr_data", wr_data, 32'd0);
    chk("R1 ld_data", ld_data, 32'd0);
    chk("R1 misalign", {31'd0, misalign}, 32'd0);
  endtask

  task automatic t_byte_store();
    for (int k = 0; k < 4; k++) begin
      issue(1'b1, 1'b0, 2'b00, 2'(k), 32'hDEAD_BE5A + 32'(k), 32'h0);
      chk("R2 enable", {28'd0, wr_en}, 32'h8 >> k);
      chk("R2 data", wr_data, {4{8'(8'h5A + k)}});
      chk("R2 flag", {31'd0, misalign}, 32'd0);
    end
  endtask

  task automatic t_half_store();
    issue(1'b1, 1'b0, 2'b01, 2'd0, 32'h1234_ABCD, 32'h0);
    chk("R3 enable ofs0", {28'd0, wr_en}, 32'hC);
    chk("R3 data ofs0", wr_data, 32'hABCD_ABCD);
    issue(1'b1, 1'b0, 2'b01, 2'd2, 32'h0000_7E01, 32'h0);
    chk("R3 enable ofs2", {28'd0, wr_en}, 32'h3);
    chk("R3 data ofs2", wr_data, 32'h7E01_7E01);
  endtask

  task automatic t_word_store();
    issue(1'b1, 1'b0, 2'b10, 2'd0, 32'hCAFE_F00D, 32'h0);
    chk("R4 enable", {28'd0, wr_en}, 32'hF);
    chk("R4 data", wr_data, 32'hCAFE_F00D);
  endtask

  task automatic t_narrow_loads();
    logic [31:0] w = 32'h80_7F_C3_01;
    logic [7:0] bytes [4];
    bytes[0] = 8'h80; bytes[1] = 8'h7F; bytes[2] = 8'hC3; bytes[3] = 8'h01;
    for (int k = 0; k < 4; k++) begin
      issue(1'b0, 1'b1, 2'b00, 2'(k), 32'h0, w);
      chk("R5 byte zero fill", ld_data, {24'd0, bytes[k]});
      chk("R9 load no enable", {28'd0, wr_en}, 32'd0);
      issue(1'b0, 1'b0, 2'b00, 2'(k), 32'h0, w);
      chk("R6 byte sign fill", ld_data,
          bytes[k][7] ? {24'hFFFFFF, bytes[k]} : {24'd0, bytes[k]});
    end
    issue(1'b0, 1'b1, 2'b01, 2'd0, 32'h0, w);
    chk("R5 half ofs0", ld_data, 32'h0000_807F);
    issue(1'b0, 1'b0, 2'b01, 2'd0, 32'h0, w);
    chk("R6 half ofs0", ld_data, 32'hFFFF_807F);
    issue(1'b0, 1'b0, 2'b01, 2'd2, 32'h0, w);
    chk("R6 half ofs2", ld_data, 32'hFFFF_C301);
    issue(1'b0, 1'b0, 2'b01, 2'd2, 32'h0, 32'h1111_7001);
    chk("R6 half positive", ld_data, 32'h0000_7001);
    issue(1'b0, 1'b1, 2'b01, 2'd2, 32'h0, w);
    chk("R5 half ofs2", ld_data, 32'h0000_C301);
  endtask

  task automatic t_word_load();
    issue(1'b0, 1'b0, 2'b10, 2'd0, 32'h0, 32'h9ABC_DEF0);
    chk("R7 signed req", ld_data, 32'h9ABC_DEF0);
    issue(1'b0, 1'b1, 2'b10, 2'd0, 32'h0, 32'h8000_0001);
    chk("R7 unsigned req", ld_data, 32'h8000_0001);
  endtask

  task automatic t_misaligned();
    issue(1'b1, 1'b0, 2'b01, 2'd1, 32'hFFFF_FFFF, 32'h0);
    chk("R8 half ofs1 flag", {31'd0, misalign}, 32'd1);
    chk("R8 half ofs1 enable", {28'd0, wr_en}, 32'd0);
    issue(1'b1, 1'b0, 2'b01, 2'd3, 32'hFFFF_FFFF, 32'h0);
    chk("R8 half ofs3 enable", {28'd0, wr_en}, 32'd0);
    for (int k = 1; k < 4; k++) begin
      issue(1'b1, 1'b0, 2'b10, 2'(k), 32'hFFFF_FFFF, 32'h0);
      chk("R8 word flag", {31'd0, misalign}, 32'd1);
      chk("R8 word enable", {28'd0, wr_en}, 32'd0);
    end
    issue(1'b1, 1'b0, 2'b11, 2'd0, 32'hFFFF_FFFF, 32'h0);
    chk("R8 reserved flag", {31'd0, misalign}, 32'd1);
    chk("R8 reserved enable", {28'd0, wr_en}, 32'd0);
    issue(1'b0, 1'b0, 2'b10, 2'd2, 32'h0, 32'hFFFF_FFFF);
    chk("R8 load flag", {31'd0, misalign}, 32'd1);
    chk("R8 load result", ld_data, 32'd0);
    issue(1'b0, 1'b1, 2'b01, 2'd1, 32'h0, 32'hFFFF_FFFF);
    chk("R8 half load result", ld_data, 32'd0);
  endtask

  task automatic t_idle();
    issue(1'b1, 1'b0, 2'b10, 2'd0, 32'h1, 32'h0);
    @(negedge clk);
    chk("R9 idle enable", {28'd0, wr_en}, 32'd0);
    chk("R9 idle flag", {31'd0, misalign}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_byte_store();
    t_half_store();
    t_word_store();
    t_narrow_loads();
    t_word_load();
    t_misaligned();
    t_idle();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule